// File: doc/BRIEF.md
# Truncated binary block decoder

This block turns a bit-serial field stream back into a block of 2^M unsigned N-bit samples. It does not hold the bitstream itself. For every field it asks an external field source for a given number of bits, then takes the right-justified value the source returns. Each block opens with an 8-bit header that picks how the block's samples are coded.

A zero header means the samples follow as raw N-bit fields and are passed on unchanged. A non-zero header with bit 7 clear selects economy coding. In that mode one plain N-bit field gives the largest value in the block, and every sample is then a phase-in (truncated binary) code over 0..max. The decoder reads a short field, compares it with a threshold derived from the range, and fetches one more bit only when the short field is at or above that threshold. A header with bit 7 set marks the tree-walking format. The decoder reports that mode but produces no samples for it, and goes straight back to waiting for a header.

Decoded samples leave as a single-cycle valid pulse with the value and a last flag. A mode output tells which format the current block uses.

Top module: `phasein_block_dec`

## Requirements
- R1: While reset is held and in the first cycle after it, `smp_vld` is 0, `mode_o` is 0 (no block), and the block requests an 8-bit header field (`fld_req`=1, `fld_len`=8).
- R2: A header of 0x00 sets `mode_o` to 1 (raw). Each of the 2^M samples is then requested as an N-bit field and output unchanged.
- R3: A non-zero header with bit 7 clear sets `mode_o` to 2 (economy). The next field requested is the N-bit block maximum.
- R4: A header with bit 7 set sets `mode_o` to 3. No sample is output, and the next field requested is again an 8-bit header.
- R5: In economy mode with max > 0, let n = max+1, k = floor(log2 n) and u = 2^(k+1) − n. Each sample first requests a k-bit field v, and when v < u the sample value is v.
- R6: When v ≥ u, the block requests one more 1-bit field b and outputs 2v + b − u.
- R7: In economy mode with max = 0, all 2^M samples are 0, one per cycle, and no field is requested between the maximum and the next header.
- R8: `smp_last` is 1 exactly on the 2^M-th sample of a block, and the block then requests a header.
- R9: A request stays asserted with a stable length until `fld_ack` is seen, and a field is transferred on a cycle where `fld_req` and `fld_ack` are both 1. A sample that consumes a field appears on the outputs one cycle after that transfer, with `smp_vld` high for one cycle.
- R10: Every economy-mode sample is no larger than the block maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fld_req | output | 1 | Field request to the bit source |
| fld_len | output | $clog2(max(N,8)+1) | Number of bits requested |
| fld_ack | input | 1 | Source presents the requested field this cycle |
| fld_data | input | max(N,8) | Requested bits, right-justified, zero-extended, first bit as MSB |
| smp_vld | output | 1 | Sample valid (one cycle) |
| smp_data | output | N | Decoded sample |
| smp_last | output | 1 | Last sample of the block |
| mode_o | output | 2 | 0 none, 1 raw, 2 economy, 3 tree-walking |

## Verification
The assertions assume that the source returns exactly the number of bits asked for, zero-extended, and that it never acks when no request is pending. The bench's source model honours this because it serves each request from a queue of fields tagged with their expected length, and it checks `fld_len` against that length before it acks. Ack gaps are inserted on a fixed cycle pattern, so requests are held across stalls. The economy streams are produced by an encoder written from R5 and R6, and they cover every maximum and every value for a 4-bit sample width, so samples below the threshold, samples at or above it, exact powers of two and max = 0 are all reached.

// File: rtl/phasein_pkg.sv
package phasein_pkg;

    localparam int HDR_W = 8;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_RAW    = 2'd1,
        MODE_ECON   = 2'd2,
        MODE_TREE   = 2'd3
    } blk_mode_t;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_MAX,
        ST_SHORT,
        ST_EXTRA,
        ST_ZERO,
        ST_RAW
    } dec_state_t;

    // floor(log2(n)) for n >= 1
    function automatic int unsigned flog2(input int unsigned n);
        int unsigned r;
        r = 0;
        for (int i = 1; i < 32; i++) begin
            if (n >= (32'd1 << i)) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/phasein_range.sv
module phasein_range
    import phasein_pkg::*;
#(
    parameter int N  = 8,
    localparam int KW = $clog2(N + 1)
) (
    input  logic [N-1:0]  max_i,
    input  logic [N-1:0]  v_i,
    input  logic          b_i,
    output logic [KW-1:0] k_o,
    output logic          long_o,
    output logic [N-1:0]  val_o
);
    int unsigned n_c;
    int unsigned k_c;
    int unsigned u_c;
    int unsigned ext_c;

    always_comb begin
        n_c    = 32'(max_i) + 32'd1;
        k_c    = flog2(n_c);
        u_c    = (32'd1 << (k_c + 32'd1)) - n_c;
        ext_c  = (32'(v_i) << 1) + 32'(b_i) - u_c;
        k_o    = KW'(k_c);
        long_o = (32'(v_i) >= u_c);
        val_o  = ext_c[N-1:0];
    end
endmodule

// File: rtl/phasein_count.sv
module phasein_count #(
    parameter int M = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last_o
);
    logic [M-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (inc)   cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = &cnt_q;
endmodule

// File: rtl/phasein_block_dec.sv
module phasein_block_dec
    import phasein_pkg::*;
#(
    parameter int N = 8,
    parameter int M = 4,
    localparam int DW = (N > HDR_W) ? N : HDR_W,
    localparam int LW = $clog2(DW + 1),
    localparam int KW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          fld_req,
    output logic [LW-1:0] fld_len,
    input  logic          fld_ack,
    input  logic [DW-1:0] fld_data,
    output logic          smp_vld,
    output logic [N-1:0]  smp_data,
    output logic          smp_last,
    output logic [1:0]    mode_o
);
    dec_state_t  state_q;
    blk_mode_t   mode_q;
    logic [N-1:0] max_q;
    logic [N-1:0] v_q;
    logic [N-1:0] v_in;
    logic [N-1:0] long_val;
    logic [N-1:0] emit_val;
    logic [KW-1:0] k_len;
    logic         is_long;
    logic         xfer;
    logic         emit;
    logic         cnt_last;

    assign xfer   = fld_req & fld_ack;
    assign v_in   = (state_q == ST_SHORT) ? fld_data[N-1:0] : v_q;
    assign mode_o = mode_q;

    phasein_range #(.N(N)) u_range (
        .max_i  (max_q),
        .v_i    (v_in),
        .b_i    (fld_data[0]),
        .k_o    (k_len),
        .long_o (is_long),
        .val_o  (long_val)
    );

    phasein_count #(.M(M)) u_count (
        .clk    (clk),
        .rst    (rst),
        .clr    ((state_q == ST_HDR) && xfer),
        .inc    (emit),
        .last_o (cnt_last)
    );

    always_comb begin
        fld_req = 1'b1;
        fld_len = LW'(HDR_W);
        case (state_q)
            ST_HDR:   fld_len = LW'(HDR_W);
            ST_MAX:   fld_len = LW'(N);
            ST_RAW:   fld_len = LW'(N);
            ST_SHORT: fld_len = LW'(k_len);
            ST_EXTRA: fld_len = LW'(1);
            default: begin
                fld_req = 1'b0;
                fld_len = '0;
            end
        endcase
    end

    always_comb begin
        emit     = 1'b0;
        emit_val = '0;
        case (state_q)
            ST_SHORT: begin
                emit     = xfer && !is_long;
                emit_val = v_in;
            end
            ST_EXTRA: begin
                emit     = xfer;
                emit_val = long_val;
            end
            ST_ZERO: begin
                emit     = 1'b1;
                emit_val = '0;
            end
            ST_RAW: begin
                emit     = xfer;
                emit_val = fld_data[N-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HDR;
            mode_q   <= MODE_NONE;
            max_q    <= '0;
            v_q      <= '0;
            smp_vld  <= 1'b0;
            smp_data <= '0;
            smp_last <= 1'b0;
        end else begin
            smp_vld  <= emit;
            smp_last <= emit && cnt_last;
            if (emit) smp_data <= emit_val;
            case (state_q)
                ST_HDR: if (xfer) begin
                    if (fld_data[HDR_W-1:0] == '0) begin
                        mode_q  <= MODE_RAW;
                        state_q <= ST_RAW;
                    end else if (fld_data[HDR_W-1]) begin
                        mode_q  <= MODE_TREE;
                    end else begin
                        mode_q  <= MODE_ECON;
                        state_q <= ST_MAX;
                    end
                end
                ST_MAX: if (xfer) begin
                    max_q   <= fld_data[N-1:0];
                    state_q <= (fld_data[N-1:0] == '0) ? ST_ZERO : ST_SHORT;
                end
                ST_SHORT: if (xfer && is_long) begin
                    v_q     <= fld_data[N-1:0];
                    state_q <= ST_EXTRA;
                end
                ST_EXTRA: if (xfer) state_q <= ST_SHORT;
                default: ;
            endcase
            if (emit && cnt_last) state_q <= ST_HDR;
        end
    end

    // R9: a pending request is held unchanged until acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        fld_req && !fld_ack |=> fld_req && $stable(fld_len));

    // R9: a field-consuming sample follows a transfer by one cycle
    p_src_r9: assert property (@(posedge clk) disable iff (rst)
        smp_vld && !(mode_q == MODE_ECON && max_q == '0) |-> $past(xfer));

    // R8: after the last sample a header is requested
    p_last_hdr_r8: assert property (@(posedge clk) disable iff (rst)
        smp_vld && smp_last |-> fld_req && fld_len == LW'(HDR_W));

    // R10: economy samples never exceed the block maximum
    p_econ_range_r10: assert property (@(posedge clk) disable iff (rst)
        smp_vld && mode_q == MODE_ECON |-> smp_data <= max_q);

    // R7: a zero maximum yields zero samples
    p_zero_r7: assert property (@(posedge clk) disable iff (rst)
        smp_vld && mode_q == MODE_ECON && max_q == '0 |-> smp_data == '0);

    // R4: tree-walking blocks produce no samples
    p_tree_r4: assert property (@(posedge clk) disable iff (rst)
        mode_q == MODE_TREE |-> !smp_vld);
endmodule

// File: tb/test_phasein_block_dec.sv
module test_phasein_block_dec;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int MB = 2;
    localparam int DW = 8;
    localparam int LW = 4;
    localparam int BLK = 1 << MB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fld_req;
    logic [LW-1:0] fld_len;
    logic          fld_ack = 1'b0;
    logic [DW-1:0] fld_data = '0;
    logic          smp_vld;
    logic [NB-1:0] smp_data;
    logic          smp_last;
    logic [1:0]    mode_o;

    typedef struct { int len; int val; string tag; } fld_t;
    typedef struct { int data; bit last; int mode; string tag; } exp_t;

    fld_t fq[$];
    exp_t eq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phasein_block_dec #(.N(NB), .M(MB)) i_phasein_block_dec (
        .clk(clk), .rst(rst), .fld_req(fld_req), .fld_len(fld_len),
        .fld_ack(fld_ack), .fld_data(fld_data), .smp_vld(smp_vld),
        .smp_data(smp_data), .smp_last(smp_last), .mode_o(mode_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push_fld(input int len, input int val, input string tag);
        fld_t f;
        f.len = len; f.val = val; f.tag = tag;
        fq.push_back(f);
    endtask

    task automatic push_exp(input int d, input bit last, input int mode, input string tag);
        exp_t e;
        e.data = d; e.last = last; e.mode = mode; e.tag = tag;
        eq.push_back(e);
    endtask

    task automatic raw_block(input int base);
        push_fld(8, 0, "R2");
        for (int i = 0; i < BLK; i++) begin
            push_fld(NB, (base + i) % (1 << NB), "R2");
            push_exp((base + i) % (1 << NB), i == BLK - 1, 1, "R2");
        end
    endtask

    // encoder written from R5/R6
    task automatic econ_block(input int mx, input int first, input int hdr);
        int n, k, u, x;
        push_fld(8, hdr, "R3");
        push_fld(NB, mx, "R3");
        n = mx + 1;
        k = 0;
        while ((1 << (k + 1)) <= n) k++;
        u = (1 << (k + 1)) - n;
        for (int i = 0; i < BLK; i++) begin
            x = (first + i) % n;
            if (mx == 0) begin
                push_exp(0, i == BLK - 1, 2, "R7");
            end else if (x < u) begin
                push_fld(k, x, "R5");
                push_exp(x, i == BLK - 1, 2, "R5");
            end else begin
                push_fld(k, (x + u) >> 1, "R6");
                push_fld(1, (x + u) & 1, "R6");
                push_exp(x, i == BLK - 1, 2, "R6");
            end
        end
    endtask

    // field source; ack gaps exercise request holding (R9)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && fld_req && fq.size() > 0 && (cyc % 5) != 3) begin
                chk(int'(fld_len) == fq[0].len, {fq[0].tag, "/R9 field length"},
                    int'(fld_len), fq[0].len);
                fld_data = DW'(fq[0].val);
                fld_ack  = 1'b1;
                void'(fq.pop_front());
            end else begin
                fld_ack  = 1'b0;
                fld_data = '0;
            end
        end
    end

    // sample monitor (R8 last flag, R10 range via expected values)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && smp_vld) begin
                if (eq.size() == 0) begin
                    chk(1'b0, "R4 unexpected sample", int'(smp_data), -1);
                end else begin
                    chk(int'(smp_data) == eq[0].data, eq[0].tag, int'(smp_data), eq[0].data);
                    chk(smp_last == eq[0].last, "R8 last flag", int'(smp_last), int'(eq[0].last));
                    chk(int'(mode_o) == eq[0].mode, "R2/R3 mode", int'(mode_o), eq[0].mode);
                    void'(eq.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    task automatic drain();
        while (fq.size() > 0 || eq.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(smp_vld == 1'b0, "R1 smp_vld", int'(smp_vld), 0);
        chk(mode_o == 2'd0, "R1 mode", int'(mode_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(smp_vld == 1'b0, "R1 smp_vld after reset", int'(smp_vld), 0);
        chk(mode_o == 2'd0, "R1 mode after reset", int'(mode_o), 0);
        chk(fld_req == 1'b1, "R1 header request", int'(fld_req), 1);
        chk(int'(fld_len) == 8, "R1 header length", int'(fld_len), 8);

        for (int b = 0; b < (1 << NB); b += BLK) raw_block(b);
        for (int mx = 0; mx < (1 << NB); mx++) begin
            for (int f = 0; f <= mx; f += BLK)
                econ_block(mx, f, (mx % 2 == 1) ? 8'h01 : 8'h7F);
        end
        econ_block(0, 0, 8'h33);
        drain();
        chk(int'(mode_o) == 2, "R3 mode held after block", int'(mode_o), 2);

        push_fld(8, 8'hA5, "R4");
        drain();
        chk(int'(mode_o) == 3, "R4 tree mode", int'(mode_o), 3);
        chk(fld_req && int'(fld_len) == 8, "R4 header requested again", int'(fld_len), 8);

        econ_block(5, 2, 8'h01);
        econ_block(15, 12, 8'h40);
        raw_block(3);
        drain();
        chk(int'(mode_o) == 1, "R2 raw mode", int'(mode_o), 1);
        finish_run();
    end
endmodule